// File: doc/BRIEF.md
# Prefixed Opcode Legality Checker

This block sits beside the opcode-fetch path of an 8-bit microcontroller core. It checks the instruction stream for the few opcodes that this core variant no longer implements. It watches each fetched byte, together with a strobe that marks the first byte of an instruction. The instruction set puts some opcodes on a second page, selected by the one-byte prefix 0x18. The checker therefore keeps a one-bit memory of a pending prefix, so that it judges the byte that follows the prefix against the second-page rules.

Three opcodes are rejected. The first is the stop instruction, 0xCF on the base page. The second is the exchange of D with X, 0x8F on the base page. The third is the exchange of D with Y, 0x8F on the prefixed page. When one of these is seen, the block raises a one-cycle trap request and reports the full 16-bit opcode. It also presents the fixed illegal-opcode vector address 0xFFF6, which the core uses to fetch the handler.

The block also contains the read path of the condition-code register. On this path the two most significant flag bits always read as one.

Top module: `opcode_legality_chk`

## Requirements
- R1: A valid fetch marked as a first byte with value 0xCF raises `trap_req` for exactly the next cycle, with `trap_opcode` = 0x00CF.
- R2: A valid first-byte fetch of 0x8F raises `trap_req` on the next cycle with `trap_opcode` = 0x008F.
- R3: A valid first-byte fetch of 0x18 raises no trap and arms a pending prefix. If the next valid fetch is not a first byte and has value 0x8F, `trap_req` rises on the following cycle with `trap_opcode` = 0x188F.
- R4: Any second-page byte other than 0x8F, including 0xCF, raises no trap. The pending prefix is consumed by exactly one following byte, so a later operand byte of 0x8F raises no trap.
- R5: If a pending prefix is followed by another first-byte fetch, the prefix is dropped without a trap, and the new byte is judged by the base-page rules. A base-page 0x8F then reports 0x008F, and a repeated 0x18 arms a fresh prefix.
- R6: A byte with the first-byte strobe low and no prefix pending never traps, even when it is 0xCF or 0x8F. Any input with `fetch_vld` low never traps.
- R7: A pending prefix persists through cycles with `fetch_vld` low. Each illegal fetch produces its own one-cycle pulse, so back-to-back illegal fetches give back-to-back pulses. `trap_opcode` holds its last value until the next trap.
- R8: `ccr_rd` equals `ccr_raw` with bits 7 and 6 forced to 1; bits 5..0 pass through unchanged.
- R9: `trap_vector` always reads 0xFFF6.
- R10: A synchronous active-high `rst` clears the pending prefix, `trap_req` and `trap_opcode`. An illegal fetch presented while `rst` is high raises no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | Fetched byte is valid this cycle |
| fetch_first | input | 1 | Fetched byte is the first byte of an instruction |
| fetch_byte | input | 8 | Fetched opcode-stream byte |
| ccr_raw | input | 8 | Stored condition-code register value |
| ccr_rd | output | 8 | Condition-code value as seen by a read |
| trap_req | output | 1 | One-cycle illegal-instruction trap request |
| trap_opcode | output | 16 | Offending opcode, prefix in the upper byte (0x00 when unprefixed) |
| trap_vector | output | 16 | Handler vector address for the trap |

## Verification
The bench targets the prefix memory at each edge of its life. It arms the prefix and then lets it sit through idle cycles; a design that cleared it too early would miss the 0x188F trap. It consumes the prefix with a legal byte and then sends an operand 0x8F; a design that left the flag armed would trap wrongly. It drops the prefix with a new first byte, and a design that judged that byte on the second page would report 0x188F instead of 0x008F. It also sends bare operand bytes of 0xCF and 0x8F, back-to-back illegal fetches, a reset that lands on an illegal fetch, and condition-code values with the top bits cleared. These expose a checker that ignores the strobes, stretches or merges pulses, lets reset lose to a trap, or fails to force the flag bits.

// File: rtl/opc_chk_pkg.sv
package opc_chk_pkg;

    localparam int BYTE_W = 8;
    localparam int OPC_W  = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [OPC_W-1:0]  opc_t;

    // Page selector byte and removed opcodes
    localparam byte_t PFX_PAGE2    = 8'h18;
    localparam byte_t OP_HALT      = 8'hCF;
    localparam byte_t OP_SWAP_DX   = 8'h8F;
    localparam byte_t OP_SWAP_DY   = 8'h8F;
    localparam byte_t PAGE_BASE_HI = 8'h00;

    // How the byte on the bus this cycle is to be judged
    typedef enum logic [1:0] {
        PG_NONE     = 2'd0,
        PG_BASE     = 2'd1,
        PG_PREFIXED = 2'd2
    } page_e;

    typedef struct packed {
        page_e page;
        byte_t b;
    } fetch_t;

    typedef struct packed {
        logic hit;
        opc_t opc;
    } verdict_t;

    function automatic logic base_removed(input byte_t b);
        return (b == OP_HALT) || (b == OP_SWAP_DX);
    endfunction

    function automatic logic page2_removed(input byte_t b);
        return (b == OP_SWAP_DY);
    endfunction

    function automatic opc_t form_opc(input page_e pg, input byte_t b);
        return (pg == PG_PREFIXED) ? {PFX_PAGE2, b} : {PAGE_BASE_HI, b};
    endfunction

endpackage

// File: rtl/opc_prefix_tracker.sv
module opc_prefix_tracker
    import opc_chk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fetch_vld,
    input  logic   fetch_first,
    input  byte_t  fetch_byte,
    output logic   pend_q,
    output fetch_t cls
);

    logic pend_d;

    // A valid fetch always resolves the flag: only a first-byte prefix arms it
    always_comb begin
        pend_d = pend_q;
        if (fetch_vld) begin
            pend_d = fetch_first && (fetch_byte == PFX_PAGE2);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    always_comb begin
        cls.b    = fetch_byte;
        cls.page = PG_NONE;
        if (fetch_vld) begin
            if (fetch_first) begin
                cls.page = PG_BASE;
            end else if (pend_q) begin
                cls.page = PG_PREFIXED;
            end
        end
    end

endmodule

// File: rtl/opc_rule_table.sv
module opc_rule_table
    import opc_chk_pkg::*;
(
    input  fetch_t   cls,
    output verdict_t verdict
);

    always_comb begin
        verdict.opc = form_opc(cls.page, cls.b);
        unique case (cls.page)
            PG_BASE:     verdict.hit = base_removed(cls.b);
            PG_PREFIXED: verdict.hit = page2_removed(cls.b);
            default:     verdict.hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/opc_trap_reg.sv
module opc_trap_reg
    import opc_chk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_t verdict,
    output logic     trap_req,
    output opc_t     trap_opc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_req <= 1'b0;
            trap_opc <= '0;
        end else begin
            trap_req <= verdict.hit;
            if (verdict.hit) begin
                trap_opc <= verdict.opc;
            end
        end
    end

endmodule

// File: rtl/ccr_read_mask.sv
module ccr_read_mask #(
    parameter int          W          = 8,
    parameter logic [W-1:0] FORCE_ONES = 8'hC0
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] rd
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (FORCE_ONES[i]) begin : g_force
            assign rd[i] = 1'b1;
        end else begin : g_pass
            assign rd[i] = raw[i];
        end
    end

endmodule

// File: rtl/opcode_legality_chk.sv
module opcode_legality_chk
    import opc_chk_pkg::*;
#(
    parameter logic [15:0] TRAP_VECTOR = 16'hFFF6,
    parameter logic [7:0]  CCR_FORCE   = 8'hC0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_vld,
    input  logic        fetch_first,
    input  logic [7:0]  fetch_byte,
    input  logic [7:0]  ccr_raw,
    output logic [7:0]  ccr_rd,
    output logic        trap_req,
    output logic [15:0] trap_opcode,
    output logic [15:0] trap_vector
);

    logic     pend_q;
    fetch_t   cls;
    verdict_t verdict;

    opc_prefix_tracker u_pfx (
        .clk         (clk),
        .rst         (rst),
        .fetch_vld   (fetch_vld),
        .fetch_first (fetch_first),
        .fetch_byte  (fetch_byte),
        .pend_q      (pend_q),
        .cls         (cls)
    );

    opc_rule_table u_rules (
        .cls     (cls),
        .verdict (verdict)
    );

    opc_trap_reg u_trap (
        .clk      (clk),
        .rst      (rst),
        .verdict  (verdict),
        .trap_req (trap_req),
        .trap_opc (trap_opcode)
    );

    ccr_read_mask #(
        .W          (BYTE_W),
        .FORCE_ONES (CCR_FORCE)
    ) u_ccr (
        .raw (ccr_raw),
        .rd  (ccr_rd)
    );

    assign trap_vector = TRAP_VECTOR;

endmodule

// File: rtl/opcode_legality_chk_sva.sv
module opcode_legality_chk_sva (
    input logic        clk,
    input logic        rst,
    input logic        fetch_vld,
    input logic        fetch_first,
    input logic [7:0]  fetch_byte,
    input logic [7:0]  ccr_raw,
    input logic [7:0]  ccr_rd,
    input logic        trap_req,
    input logic [15:0] trap_opcode,
    input logic        pend_q
);

    a_r1_halt_traps: assert property (@(posedge clk) disable iff (rst)
        (fetch_vld && fetch_first && fetch_byte == 8'hCF)
        |=> (trap_req && trap_opcode == 16'h00CF));

    a_r2_swap_dx_traps: assert property (@(posedge clk) disable iff (rst)
        (fetch_vld && fetch_first && fetch_byte == 8'h8F)
        |=> (trap_req && trap_opcode == 16'h008F));

    a_r3_swap_dy_traps: assert property (@(posedge clk) disable iff (rst)
        (fetch_vld && !fetch_first && pend_q && fetch_byte == 8'h8F)
        |=> (trap_req && trap_opcode == 16'h188F));

    a_r6_operand_quiet: assert property (@(posedge clk) disable iff (rst)
        ((fetch_vld && !fetch_first && !pend_q) || !fetch_vld)
        |=> !trap_req);

    a_r7_pend_holds_idle: assert property (@(posedge clk) disable iff (rst)
        (!fetch_vld) |=> $stable(pend_q));

    a_r8_ccr_forced: assert property (@(posedge clk) disable iff (rst)
        (ccr_rd[7:6] == 2'b11) && (ccr_rd[5:0] == ccr_raw[5:0]));

endmodule

bind opcode_legality_chk opcode_legality_chk_sva u_sva (
    .clk         (clk),
    .rst         (rst),
    .fetch_vld   (fetch_vld),
    .fetch_first (fetch_first),
    .fetch_byte  (fetch_byte),
    .ccr_raw     (ccr_raw),
    .ccr_rd      (ccr_rd),
    .trap_req    (trap_req),
    .trap_opcode (trap_opcode),
    .pend_q      (pend_q)
);

// File: tb/opcode_legality_chk_tb_top.sv
module opcode_legality_chk_tb_top;

    localparam int CLK_P   = 10;
    localparam int N_VEC   = 22;
    localparam int WD_CYC  = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_vld;
    logic        fetch_first;
    logic [7:0]  fetch_byte;
    logic [7:0]  ccr_raw;
    logic [7:0]  ccr_rd;
    logic        trap_req;
    logic [15:0] trap_opcode;
    logic [15:0] trap_vector;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    opcode_legality_chk dut_i (
        .clk         (clk),
        .rst         (rst),
        .fetch_vld   (fetch_vld),
        .fetch_first (fetch_first),
        .fetch_byte  (fetch_byte),
        .ccr_raw     (ccr_raw),
        .ccr_rd      (ccr_rd),
        .trap_req    (trap_req),
        .trap_opcode (trap_opcode),
        .trap_vector (trap_vector)
    );

    // {vld, first, byte, exp_trap, exp_opcode}
    localparam logic [26:0] VECS [N_VEC] = '{
        {1'b1, 1'b1, 8'hCF, 1'b1, 16'h00CF},  // 0  R1 halt
        {1'b0, 1'b0, 8'h00, 1'b0, 16'h00CF},  // 1  R7 pulse ends, opcode held
        {1'b1, 1'b1, 8'h8F, 1'b1, 16'h008F},  // 2  R2 swap D,X
        {1'b1, 1'b1, 8'h18, 1'b0, 16'h008F},  // 3  R3 prefix itself legal
        {1'b1, 1'b0, 8'h8F, 1'b1, 16'h188F},  // 4  R3 swap D,Y
        {1'b1, 1'b0, 8'h8F, 1'b0, 16'h188F},  // 5  R4 prefix consumed
        {1'b1, 1'b1, 8'h18, 1'b0, 16'h188F},  // 6  R4 prefix
        {1'b1, 1'b0, 8'hCF, 1'b0, 16'h188F},  // 7  R4 prefixed CF legal
        {1'b1, 1'b1, 8'h18, 1'b0, 16'h188F},  // 8  R7 prefix
        {1'b0, 1'b0, 8'h8F, 1'b0, 16'h188F},  // 9  R7 idle keeps prefix
        {1'b1, 1'b0, 8'h8F, 1'b1, 16'h188F},  // 10 R7 prefix survived
        {1'b1, 1'b1, 8'h18, 1'b0, 16'h188F},  // 11 R5 prefix
        {1'b1, 1'b1, 8'h8F, 1'b1, 16'h008F},  // 12 R5 dropped, base rule
        {1'b1, 1'b0, 8'hCF, 1'b0, 16'h008F},  // 13 R6 operand CF
        {1'b1, 1'b0, 8'h8F, 1'b0, 16'h008F},  // 14 R6 operand 8F
        {1'b0, 1'b1, 8'hCF, 1'b0, 16'h008F},  // 15 R6 strobe low
        {1'b1, 1'b1, 8'hCF, 1'b1, 16'h00CF},  // 16 R7 back to back
        {1'b1, 1'b1, 8'hCF, 1'b1, 16'h00CF},  // 17 R7 back to back
        {1'b1, 1'b1, 8'h18, 1'b0, 16'h00CF},  // 18 R5 prefix
        {1'b1, 1'b1, 8'h18, 1'b0, 16'h00CF},  // 19 R5 re-armed
        {1'b1, 1'b0, 8'h8F, 1'b1, 16'h188F},  // 20 R5 fresh prefix works
        {1'b1, 1'b1, 8'h00, 1'b0, 16'h188F}   // 21 R6 legal opcode
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic f, input logic [7:0] b);
        @(negedge clk);
        fetch_vld   = v;
        fetch_first = f;
        fetch_byte  = b;
    endtask

    task automatic settle;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * WD_CYC);
        n_chk++;
        n_fail++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        fetch_vld = 1'b0;
        fetch_first = 1'b0;
        fetch_byte = 8'h00;
        ccr_raw = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 reset trap_req", {15'd0, trap_req}, 16'h0000);
        chk("R10 reset trap_opcode", trap_opcode, 16'h0000);
        chk("R9 vector", trap_vector, 16'hFFF6);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < N_VEC; i++) begin
            drive(VECS[i][26], VECS[i][25], VECS[i][24:17]);
            settle();
            chk($sformatf("R1-7 vec %0d trap", i), {15'd0, trap_req}, {15'd0, VECS[i][16]});
            chk($sformatf("R1-7 vec %0d opcode", i), trap_opcode, VECS[i][15:0]);
        end

        // R8: condition-code read path
        ccr_raw = 8'h00; #1;
        chk("R8 ccr 00", {8'd0, ccr_rd}, 16'h00C0);
        ccr_raw = 8'h3A; #1;
        chk("R8 ccr 3A", {8'd0, ccr_rd}, 16'h00FA);
        ccr_raw = 8'h7F; #1;
        chk("R8 ccr 7F", {8'd0, ccr_rd}, 16'h00FF);
        ccr_raw = 8'h95; #1;
        chk("R8 ccr 95", {8'd0, ccr_rd}, 16'h00D5);

        // R10: reset clears a pending prefix
        drive(1'b1, 1'b1, 8'h18);
        settle();
        @(negedge clk);
        rst = 1'b1;
        fetch_vld = 1'b0;
        settle();
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, 1'b0, 8'h8F);
        settle();
        chk("R10 prefix cleared", {15'd0, trap_req}, 16'h0000);
        chk("R10 opcode cleared", trap_opcode, 16'h0000);

        // R10: illegal fetch during reset is not trapped
        @(negedge clk);
        rst = 1'b1;
        fetch_vld = 1'b1;
        fetch_first = 1'b1;
        fetch_byte = 8'hCF;
        settle();
        chk("R10 no trap in reset", {15'd0, trap_req}, 16'h0000);
        @(negedge clk);
        rst = 1'b0;
        fetch_vld = 1'b0;
        settle();
        chk("R10 no late trap", {15'd0, trap_req}, 16'h0000);
        chk("R9 vector after run", trap_vector, 16'hFFF6);

        finish_run();
    end

endmodule